// File: doc/BRIEF.md
# AGC Gain Register Handoff Controller

This block is a small control register file for an audio input gain path. It holds eight byte-wide control registers behind a synchronous host read/write port. One 7-bit gain register is shared between the host and an automatic gain control (AGC) engine, and the block decides which of the two owns it. While AGC runs, the engine's updates land in the gain register and host writes to it are dropped. A host read of the gain register always returns the live value.

Two conditions restore register defaults. A reset or a chip power-off input restores all eight registers. An ADC power-down bit restores only the four gain-path registers. When the ADC power-down bit is cleared, a settling timer starts. It counts sample-period strobes and keeps AGC off until 260 or 516 strobes have arrived; a clock-mode bit picks which count applies. AGC then starts without any host action, provided its enable bit is set. On the first active cycle the block pulses a seed strobe. In that cycle the gain output carries the value the engine must start from.

Top module: `agc_gain_regfile`

## Requirements
- R1: After `rst`, the registers at addresses 0 to 7 hold 03h, 01h, 10h, 36h, 00h, 07h, 00h and 80h, `host_rdata` is 00h and `agc_active` is 0.
- R2: A one-cycle pulse on `hard_pd` restores every register to the R1 default, just as `rst` does.
- R3: A read request returns data on `host_rdata` one cycle after `host_re`. Only implemented bits are stored, and every other bit reads as 0. The implemented-bit masks for addresses 0 to 7 are 83h, CFh, 7Fh, 7Fh, FFh, 0Fh, 00h and FFh.
- R4: Bit 7 of address 0 is the AGC enable. While AGC is not active, a host write to address 2 stores the low 7 bits of the write data as the gain.
- R5: While `agc_active` is 1, host writes to address 2 are discarded, and reads of address 2 return the current gain value.
- R6: A gain update on `eng_valid`/`eng_gain` is taken into address 2 only while `agc_active` is 1. At other times it has no effect on `gain_out`.
- R7: `seed_load` pulses for exactly the first cycle in which `agc_active` is 1. In that cycle `gain_out` equals the value held in address 2 when AGC started.
- R8: Bit 0 of address 5 is the ADC power-down bit. While it is 1, addresses 0 to 3 are held at their defaults from the cycle after it is seen set, host writes to them have no effect, and `agc_active` is 0.
- R9: After the ADC power-down bit clears, register writes take effect at once, but `agc_active` stays 0 until `fs_tick` has pulsed 516 times (when bit 3 of address 5, the clock-mode bit, is 1) or 260 times (when it is 0). After that, AGC becomes active without further host action if enabled.
- R10: A write to address 5 changes the clock-mode bit (bit 3) only when bits 2:0 of address 5 are all 1 at the time of the write. Otherwise that bit keeps its value while the other bits are written.
- R11: Setting the ADC power-down bit again restarts the settling count from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hard_pd | input | 1 | Synchronous active-high chip power-off, restores all defaults |
| fs_tick | input | 1 | One-cycle strobe per audio sample period |
| host_we | input | 1 | Host write request |
| host_re | input | 1 | Host read request |
| host_addr | input | 3 | Register address |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Read data, valid the cycle after `host_re` |
| eng_valid | input | 1 | AGC engine gain update strobe |
| eng_gain | input | 7 | AGC engine gain value |
| regs_flat | output | 64 | All eight registers, address n in bits 8n+7:8n |
| agc_active | output | 1 | AGC currently owns the gain register |
| seed_load | output | 1 | One-cycle pulse when AGC takes ownership |
| gain_out | output | 7 | Gain value for the analog stage |

## Verification
The assertions assume the host issues at most one request per cycle and that `fs_tick` is a single-cycle strobe. They also assume `eng_valid` never arrives in the same cycle as a host write to the gain register. The bench keeps to these rules because each of its tasks drives a single request or strobe for one cycle and then drops it. The stimulus always raises the ADC power-down bit before it changes the clock-mode bit.

// File: rtl/agc_regs_pkg.sv
package agc_regs_pkg;
  localparam int REG_W       = 8;
  localparam int ADDR_W      = 3;
  localparam int NREG        = 1 << ADDR_W;
  localparam int GAIN_W      = 7;
  localparam int ADR_CTRL    = 0;
  localparam int ADR_GAIN    = 2;
  localparam int ADR_PWR     = 5;
  localparam int LAST_FORCED = 3;
  localparam int AGC_EN_BIT  = 7;
  localparam int ADC_PD_BIT  = 0;
  localparam int MSEL_BIT    = 3;
  localparam int PD_BITS     = 3;

  typedef logic [REG_W-1:0] byte_t;

  function automatic byte_t reg_default(input int idx);
    case (idx)
      0: return 8'h03;
      1: return 8'h01;
      2: return 8'h10;
      3: return 8'h36;
      5: return 8'h07;
      7: return 8'h80;
      default: return 8'h00;
    endcase
  endfunction

  function automatic byte_t reg_mask(input int idx);
    case (idx)
      0: return 8'h83;
      1: return 8'hCF;
      2: return 8'h7F;
      3: return 8'h7F;
      4: return 8'hFF;
      5: return 8'h0F;
      7: return 8'hFF;
      default: return 8'h00;
    endcase
  endfunction
endpackage

// File: rtl/agc_settle_timer.sv
module agc_settle_timer #(
  parameter int LONG_CNT  = 516,
  parameter int SHORT_CNT = 260
) (
  input  logic clk,
  input  logic clear,
  input  logic tick,
  input  logic long_mode,
  output logic done
);
  localparam int MAXC = (LONG_CNT > SHORT_CNT) ? LONG_CNT : SHORT_CNT;
  localparam int CW   = $clog2(MAXC + 1);

  logic [CW-1:0] cnt;
  logic [CW-1:0] limit;

  assign limit = long_mode ? CW'(LONG_CNT) : CW'(SHORT_CNT);
  assign done  = (cnt >= limit);

  always_ff @(posedge clk) begin
    if (clear)
      cnt <= '0;
    else if (tick && !done)
      cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/agc_gain_owner.sv
module agc_gain_owner (
  input  logic clk,
  input  logic clr,
  input  logic agc_en,
  input  logic adc_pd,
  input  logic settled,
  output logic agc_active,
  output logic seed_load
);
  logic active_q;

  assign agc_active = agc_en && !adc_pd && settled;
  assign seed_load  = agc_active && !active_q;

  always_ff @(posedge clk) begin
    if (clr)
      active_q <= 1'b0;
    else
      active_q <= agc_active;
  end
endmodule

// File: rtl/agc_reg_slot.sv
module agc_reg_slot
  import agc_regs_pkg::*;
#(
  parameter int IDX = 0
) (
  input  logic              clk,
  input  logic              clr,
  input  logic              force_def,
  input  logic              host_wr,
  input  byte_t             host_wdata,
  input  logic              gain_own,
  input  logic              eng_valid,
  input  logic [GAIN_W-1:0] eng_gain,
  output byte_t             q
);
  localparam byte_t DEF  = reg_default(IDX);
  localparam byte_t MASK = reg_mask(IDX);
  localparam bit FORCED  = (IDX <= LAST_FORCED);
  localparam bit IS_GAIN = (IDX == ADR_GAIN);
  localparam bit IS_PWR  = (IDX == ADR_PWR);

  byte_t wr_val;
  byte_t eng_val;

  always_comb begin
    wr_val = host_wdata & MASK;
    if (IS_PWR && !(&q[PD_BITS-1:0]))
      wr_val[MSEL_BIT] = q[MSEL_BIT];
  end

  assign eng_val = byte_t'(eng_gain) & MASK;

  always_ff @(posedge clk) begin
    if (clr || (FORCED && force_def))
      q <= DEF;
    else if (IS_GAIN && gain_own) begin
      if (eng_valid)
        q <= eng_val;
    end else if (host_wr)
      q <= wr_val;
  end
endmodule

// File: rtl/agc_gain_regfile.sv
module agc_gain_regfile
  import agc_regs_pkg::*;
#(
  parameter int LOCK_LONG  = 516,
  parameter int LOCK_SHORT = 260
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    hard_pd,
  input  logic                    fs_tick,
  input  logic                    host_we,
  input  logic                    host_re,
  input  logic [ADDR_W-1:0]       host_addr,
  input  logic [REG_W-1:0]        host_wdata,
  output logic [REG_W-1:0]        host_rdata,
  input  logic                    eng_valid,
  input  logic [GAIN_W-1:0]       eng_gain,
  output logic [NREG*REG_W-1:0]   regs_flat,
  output logic                    agc_active,
  output logic                    seed_load,
  output logic [GAIN_W-1:0]       gain_out
);
  byte_t bank [NREG];
  logic  clr_all;
  logic  adc_pd;
  logic  settled;

  assign clr_all = rst || hard_pd;
  assign adc_pd  = bank[ADR_PWR][ADC_PD_BIT];

  for (genvar i = 0; i < NREG; i++) begin : g_slot
    agc_reg_slot #(.IDX(i)) u_slot (
      .clk        (clk),
      .clr        (clr_all),
      .force_def  (adc_pd),
      .host_wr    (host_we && (host_addr == ADDR_W'(i))),
      .host_wdata (host_wdata),
      .gain_own   (agc_active),
      .eng_valid  (eng_valid),
      .eng_gain   (eng_gain),
      .q          (bank[i])
    );
    assign regs_flat[i*REG_W +: REG_W] = bank[i];
  end

  agc_settle_timer #(.LONG_CNT(LOCK_LONG), .SHORT_CNT(LOCK_SHORT)) u_timer (
    .clk       (clk),
    .clear     (clr_all || adc_pd),
    .tick      (fs_tick),
    .long_mode (bank[ADR_PWR][MSEL_BIT]),
    .done      (settled)
  );

  agc_gain_owner u_owner (
    .clk        (clk),
    .clr        (clr_all),
    .agc_en     (bank[ADR_CTRL][AGC_EN_BIT]),
    .adc_pd     (adc_pd),
    .settled    (settled),
    .agc_active (agc_active),
    .seed_load  (seed_load)
  );

  assign gain_out = bank[ADR_GAIN][GAIN_W-1:0];

  always_ff @(posedge clk) begin
    if (clr_all)
      host_rdata <= '0;
    else if (host_re)
      host_rdata <= bank[host_addr];
  end
endmodule

// File: rtl/agc_gain_regfile_chk.sv
module agc_gain_regfile_chk #(
  parameter int LOCK_LONG  = 516,
  parameter int LOCK_SHORT = 260
) (
  input logic        clk,
  input logic        rst,
  input logic        hard_pd,
  input logic        fs_tick,
  input logic        host_we,
  input logic        host_re,
  input logic [2:0]  host_addr,
  input logic [7:0]  host_rdata,
  input logic        eng_valid,
  input logic [6:0]  eng_gain,
  input logic [63:0] regs_flat,
  input logic        agc_active,
  input logic        seed_load,
  input logic [6:0]  gain_out
);
  logic        adc_pd;
  logic        msel;
  logic [2:0]  pd3;
  logic [15:0] ticks_seen;
  logic [15:0] need;

  assign adc_pd = regs_flat[40];
  assign msel   = regs_flat[43];
  assign pd3    = regs_flat[42:40];
  assign need   = msel ? 16'(LOCK_LONG) : 16'(LOCK_SHORT);

  always_ff @(posedge clk) begin
    if (rst || hard_pd || adc_pd)
      ticks_seen <= '0;
    else if (fs_tick && ticks_seen != 16'hFFFF)
      ticks_seen <= ticks_seen + 1'b1;
  end

  a_r9_lockout: assert property (@(posedge clk) disable iff (rst || hard_pd)
    agc_active |-> ticks_seen >= need);

  a_r5_host_blocked: assert property (@(posedge clk) disable iff (rst || hard_pd)
    (agc_active && host_we && host_addr == 3'd2 && !eng_valid) |=> $stable(gain_out));

  a_r6_engine_taken: assert property (@(posedge clk) disable iff (rst || hard_pd)
    (agc_active && eng_valid) |=> gain_out == $past(eng_gain));

  a_r8_forced_default: assert property (@(posedge clk) disable iff (rst || hard_pd)
    (adc_pd && $past(adc_pd)) |-> (gain_out == 7'h10 && !agc_active));

  a_r10_msel_locked: assert property (@(posedge clk) disable iff (rst || hard_pd)
    (pd3 != 3'b111) |=> $stable(msel));

  a_r3_read_latency: assert property (@(posedge clk) disable iff (rst || hard_pd)
    (host_re && host_addr == 3'd2) |=> host_rdata == {1'b0, $past(gain_out)});

  a_r7_seed_edge: assert property (@(posedge clk) disable iff (rst || hard_pd)
    seed_load |-> (agc_active && !$past(agc_active)));
endmodule

bind agc_gain_regfile agc_gain_regfile_chk #(
  .LOCK_LONG (LOCK_LONG),
  .LOCK_SHORT(LOCK_SHORT)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .hard_pd    (hard_pd),
  .fs_tick    (fs_tick),
  .host_we    (host_we),
  .host_re    (host_re),
  .host_addr  (host_addr),
  .host_rdata (host_rdata),
  .eng_valid  (eng_valid),
  .eng_gain   (eng_gain),
  .regs_flat  (regs_flat),
  .agc_active (agc_active),
  .seed_load  (seed_load),
  .gain_out   (gain_out)
);

// File: tb/agc_gain_regfile_test.sv
module agc_gain_regfile_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        hard_pd = 1'b0;
  logic        fs_tick = 1'b0;
  logic        host_we = 1'b0;
  logic        host_re = 1'b0;
  logic [2:0]  host_addr = '0;
  logic [7:0]  host_wdata = '0;
  logic [7:0]  host_rdata;
  logic        eng_valid = 1'b0;
  logic [6:0]  eng_gain = '0;
  logic [63:0] regs_flat;
  logic        agc_active;
  logic        seed_load;
  logic [6:0]  gain_out;

  int n_checks = 0;
  int n_fail   = 0;
  int exp_q[$];
  string tag_q[$];
  logic pend = 1'b0;

  always #5 clk = ~clk;

  agc_gain_regfile uut (
    .clk(clk), .rst(rst), .hard_pd(hard_pd), .fs_tick(fs_tick),
    .host_we(host_we), .host_re(host_re), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata),
    .eng_valid(eng_valid), .eng_gain(eng_gain), .regs_flat(regs_flat),
    .agc_active(agc_active), .seed_load(seed_load), .gain_out(gain_out)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Scoreboard monitor: compares each read return against the queued expectation.
  always @(negedge clk) begin
    if (pend) begin
      if (exp_q.size() == 0) begin
        chk("R3 unexpected read return", 1, 0);
      end else begin
        chk(tag_q.pop_front(), int'(host_rdata), exp_q.pop_front());
      end
    end
    pend = host_re;
  end

  task automatic rd(input int a, input int exp, input string tag);
    @(posedge clk); #1;
    host_re = 1'b1; host_addr = 3'(a);
    exp_q.push_back(exp); tag_q.push_back(tag);
    @(posedge clk); #1;
    host_re = 1'b0;
  endtask

  task automatic wr(input int a, input int d);
    @(posedge clk); #1;
    host_we = 1'b1; host_addr = 3'(a); host_wdata = 8'(d);
    @(posedge clk); #1;
    host_we = 1'b0;
  endtask

  task automatic eng(input int g);
    @(posedge clk); #1;
    eng_valid = 1'b1; eng_gain = 7'(g);
    @(posedge clk); #1;
    eng_valid = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int k = 0; k < n; k++) begin
      @(posedge clk); #1; fs_tick = 1'b1;
      @(posedge clk); #1; fs_tick = 1'b0;
    end
  endtask

  task automatic finish_run;
    repeat (4) @(posedge clk);
    if (exp_q.size() != 0) chk("R3 reads left unanswered", exp_q.size(), 0);
    $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    #2_000_000;
    n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    // R1 reset state
    chk("R1 rdata after reset", int'(host_rdata), 0);
    chk("R1 agc_active after reset", int'(agc_active), 0);
    rd(0, 'h03, "R1 reg0"); rd(1, 'h01, "R1 reg1"); rd(2, 'h10, "R1 reg2");
    rd(3, 'h36, "R1 reg3"); rd(4, 'h00, "R1 reg4"); rd(5, 'h07, "R1 reg5");
    rd(6, 'h00, "R1 reg6"); rd(7, 'h80, "R1 reg7");

    // R10 clock-mode bit accepted while all power-down bits are set
    wr(5, 'hFF); rd(5, 'h0F, "R10 msel set under full power-down");
    wr(5, 'h0E); rd(5, 'h0E, "R9 adc power-down cleared, msel kept");

    // R3 masks, R4 direct gain write
    for (int a = 0; a < 8; a++) if (a != 5) wr(a, 'hFF);
    rd(0, 'h83, "R3 mask reg0"); rd(1, 'hCF, "R3 mask reg1");
    rd(2, 'h7F, "R4 gain direct write"); rd(3, 'h7F, "R3 mask reg3");
    rd(4, 'hFF, "R3 mask reg4"); rd(6, 'h00, "R3 mask reg6"); rd(7, 'hFF, "R3 mask reg7");
    chk("R9 agc held off during settling", int'(agc_active), 0);
    wr(0, 'h00); wr(2, 'h25); rd(2, 'h25, "R4 gain write with agc off");

    // R10 blocked when power-down bits not all 1
    wr(5, 'h06); rd(5, 'h0E, "R10 msel unchanged");

    // R9 long lockout
    wr(0, 'h80);
    ticks(515);
    chk("R9 inactive after 515 ticks", int'(agc_active), 0);
    ticks(1);
    chk("R9 active after 516 ticks", int'(agc_active), 1);
    chk("R7 seed pulse", int'(seed_load), 1);
    chk("R7 seed gain", int'(gain_out), 'h25);
    @(posedge clk); #1;
    chk("R7 seed pulse one cycle", int'(seed_load), 0);

    // R5 host write dropped, R6 engine update taken
    wr(2, 'h55); rd(2, 'h25, "R5 host write discarded");
    eng('h3A);
    chk("R6 engine gain applied", int'(gain_out), 'h3A);
    rd(2, 'h3A, "R5 read returns live gain");

    // R6 engine ignored when agc off
    wr(0, 'h00);
    chk("R4 agc off", int'(agc_active), 0);
    eng('h11);
    chk("R6 engine ignored when off", int'(gain_out), 'h3A);
    wr(2, 'h44);
    wr(0, 'h80);
    chk("R7 reactivation seed pulse", int'(seed_load), 1);
    chk("R7 reactivation seed gain", int'(gain_out), 'h44);

    // R8 adc power-down forces defaults
    wr(5, 'h0F);
    chk("R8 agc off under power-down", int'(agc_active), 0);
    rd(0, 'h03, "R8 reg0 default"); rd(1, 'h01, "R8 reg1 default");
    rd(2, 'h10, "R8 reg2 default"); rd(3, 'h36, "R8 reg3 default");
    wr(2, 'h22); rd(2, 'h10, "R8 write ignored under power-down");
    rd(4, 'hFF, "R8 reg4 untouched");

    // R10 msel cleared under full power-down, then short lockout with restart (R11)
    wr(5, 'h07); rd(5, 'h07, "R10 msel cleared");
    wr(5, 'h06); wr(0, 'h80);
    ticks(259);
    chk("R9 short inactive at 259", int'(agc_active), 0);
    wr(5, 'h07); wr(5, 'h06); wr(0, 'h80);
    ticks(259);
    chk("R11 count restarted", int'(agc_active), 0);
    ticks(1);
    chk("R9 short active at 260", int'(agc_active), 1);
    chk("R7 seed gain default", int'(gain_out), 'h10);

    // R2 chip power-off
    @(posedge clk); #1 hard_pd = 1'b1;
    @(posedge clk); #1 hard_pd = 1'b0;
    chk("R2 agc off after power-off", int'(agc_active), 0);
    rd(4, 'h00, "R2 reg4 default"); rd(5, 'h07, "R2 reg5 default");
    rd(7, 'h80, "R2 reg7 default"); rd(0, 'h03, "R2 reg0 default");

    finish_run();
  end
endmodule